// File: doc/BRIEF.md
# Control-Register Bus Handshake Sequencer

This block runs single register transactions on a narrow control-register bus that has one shared 16-bit input field, four strobes (capture address, capture data, read, write) and one acknowledge line. A host asks for a transaction through a small command port: operation, address, write data, merge mask and a one-cycle start. The sequencer then produces the bus phases one after another. It hands back read data, a one-cycle done and an error flag.

Every transaction begins with an address phase. A read then runs a read phase. A write runs a data-capture phase followed by a commit phase. A read-modify-write does a full read, merges the mask and value into the read result, and then does a full write with a second address phase. Each phase holds the value steady with no strobe for a setup interval. It then raises its strobe, polls acknowledge at a fixed interval until it is seen high, drops the strobe, and polls until acknowledge is low again. A bounded poll count guards each of these waits.

Top module: `crbus_seq`

## Requirements
- R1: An address phase drives `cmd_addr` on `bus_din` and raises `bus_cap_addr` while `bus_din` keeps that value; every operation starts with one.
- R2: Once a strobe is raised it stays high, with `bus_din` unchanged, until acknowledge is seen high at a poll. The strobe then falls, and the next phase starts only after acknowledge is seen low at a poll.
- R3: A read phase drives `bus_din` to zero and raises `bus_rd`. `rdata` takes `bus_dout` as sampled at the poll that sees acknowledge high and holds it until the next read.
- R4: A write runs a data phase (`bus_cap_data` with `cmd_wdata` on `bus_din`) and then a commit phase (`bus_wr` with the same value), each with a full handshake.
- R5: Before any strobe rises, `bus_din` has carried the phase value with all strobes low for SETUP_CYC cycles (2 by default).
- R6: Acknowledge is polled once every POLL_INT cycles. If MAX_POLLS polls in one wait do not see the awaited level, all strobes fall, the sequencer goes idle, and `done` and `err` are high together for exactly one cycle.
- R7: `busy` is high from the cycle after an accepted start until the cycle `done` rises. A start while busy is ignored, and each accepted start yields exactly one `done`.
- R8: `cmd_op` encoding: 2'b00 read, 2'b01 write, 2'b10 or 2'b11 read-modify-write. A read-modify-write reads the register, writes `(old & ~cmd_mask) | (cmd_wdata & cmd_mask)`, leaves the old value on `rdata`, and gives a single `done`.
- R9: At most one strobe is high at any time.
- R10: After reset, all strobes, `busy`, `done`, `err`, `bus_din` and `rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle transaction request |
| cmd_op | input | 2 | Operation select (see R8) |
| cmd_addr | input | DW | Register address |
| cmd_wdata | input | DW | Write value or merge value |
| cmd_mask | input | DW | Merge mask for read-modify-write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout, valid with done |
| rdata | output | DW | Last read value |
| bus_din | output | DW | Shared address/data field to the bus |
| bus_cap_addr | output | 1 | Capture-address strobe |
| bus_cap_data | output | 1 | Capture-data strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_ack | input | 1 | Acknowledge from the bus |
| bus_dout | input | DW | Read data from the bus |

## Verification
The latency of a transaction depends on how fast the responder acknowledges. For this reason the bench checks results when `done` is seen, not at a fixed cycle, and sweeps the responder delay from zero to three cycles across all sixteen model registers. Timeouts are the exception: the bench checks that `done` with `err` arrives no sooner than POLL_INT times MAX_POLLS cycles after the start, and no more than a fixed setup margin later, and that `done` is low on the following cycle. Setup, hold and single-strobe rules are checked on every cycle by a bus monitor on the falling edge, so every register-driven output is sampled half a cycle after it changes.

// File: rtl/crbus_pkg.sv
package crbus_pkg;

  localparam logic [1:0] OP_READ  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;

  typedef enum logic [1:0] {K_CAPA, K_CAPD, K_RD, K_WR} strobe_kind_e;

  typedef enum logic [1:0] {H_IDLE, H_SETUP, H_HIGH, H_LOW} hs_state_e;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_RD, S_DATA, S_COMMIT} seq_state_e;

endpackage

// File: rtl/crbus_rst_sync.sv
module crbus_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/crbus_poll_timer.sv
module crbus_poll_timer #(
  parameter int POLL_INT  = 5,
  parameter int MAX_POLLS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  input  logic run,
  output logic poll,
  output logic last
);
  localparam int PW = (POLL_INT  > 1) ? $clog2(POLL_INT)  : 1;
  localparam int NW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;

  logic [PW-1:0] pcnt_q;
  logic [NW-1:0] ncnt_q;

  assign poll = run && (pcnt_q == PW'(POLL_INT - 1));
  assign last = (ncnt_q == NW'(MAX_POLLS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pcnt_q <= '0;
    else if (reload) pcnt_q <= '0;
    else if (run)    pcnt_q <= poll ? '0 : pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ncnt_q <= '0;
    else if (reload)         ncnt_q <= '0;
    else if (poll && !last)  ncnt_q <= ncnt_q + 1'b1;
  end
endmodule

// File: rtl/crbus_hs_engine.sv
module crbus_hs_engine
  import crbus_pkg::*;
#(
  parameter int DW        = 16,
  parameter int SETUP_CYC = 2,
  parameter int POLL_INT  = 5,
  parameter int MAX_POLLS = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  strobe_kind_e  go_kind,
  input  logic [DW-1:0] go_data,
  input  logic          ack,
  input  logic [DW-1:0] dout,
  output logic [DW-1:0] din,
  output logic [3:0]    strobe,
  output logic          hs_done,
  output logic          hs_err,
  output logic [DW-1:0] rdata
);
  localparam int SW = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;

  hs_state_e     st_q, st_d;
  strobe_kind_e  kind_q;
  logic [DW-1:0] din_q, rdata_q;
  logic [SW-1:0] scnt_q;
  logic          t_reload, t_run, t_poll, t_last, cap_rd, load_en;

  assign t_run   = (st_q == H_HIGH) || (st_q == H_LOW);
  assign load_en = go && (st_q == H_IDLE);

  crbus_poll_timer #(.POLL_INT(POLL_INT), .MAX_POLLS(MAX_POLLS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (t_reload),
    .run    (t_run),
    .poll   (t_poll),
    .last   (t_last)
  );

  always_comb begin
    st_d     = st_q;
    t_reload = 1'b0;
    hs_done  = 1'b0;
    hs_err   = 1'b0;
    cap_rd   = 1'b0;
    case (st_q)
      H_IDLE:  if (go) st_d = H_SETUP;
      H_SETUP: if (scnt_q == SW'(SETUP_CYC - 1)) begin
                 st_d     = H_HIGH;
                 t_reload = 1'b1;
               end
      H_HIGH:  if (t_poll) begin
                 if (ack) begin
                   st_d     = H_LOW;
                   t_reload = 1'b1;
                   cap_rd   = (kind_q == K_RD);
                 end else if (t_last) begin
                   st_d   = H_IDLE;
                   hs_err = 1'b1;
                 end
               end
      H_LOW:   if (t_poll) begin
                 if (!ack) begin
                   st_d    = H_IDLE;
                   hs_done = 1'b1;
                 end else if (t_last) begin
                   st_d   = H_IDLE;
                   hs_err = 1'b1;
                 end
               end
      default: st_d = H_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= H_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_CAPA;
      din_q  <= '0;
    end else if (load_en) begin
      kind_q <= go_kind;
      din_q  <= go_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                scnt_q <= '0;
    else if (st_q == H_SETUP)  scnt_q <= scnt_q + 1'b1;
    else                       scnt_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_rd) rdata_q <= dout;
  end

  for (genvar k = 0; k < 4; k++) begin : g_strobe
    assign strobe[k] = (st_q == H_HIGH) && (kind_q == strobe_kind_e'(k));
  end

  assign din   = din_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/crbus_seq.sv
module crbus_seq
  import crbus_pkg::*;
#(
  parameter int DW        = 16,
  parameter int SETUP_CYC = 2,
  parameter int POLL_INT  = 5,
  parameter int MAX_POLLS = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic [DW-1:0] cmd_mask,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] bus_din,
  output logic          bus_cap_addr,
  output logic          bus_cap_data,
  output logic          bus_rd,
  output logic          bus_wr,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_dout
);
  logic          rst_n_s;
  seq_state_e    sq_q, sq_d;
  logic [1:0]    op_q;
  logic [DW-1:0] addr_q, wdata_q, mask_q, gdata_q, ldata, merged;
  strobe_kind_e  gkind_q, lkind;
  logic          go_q, wpass_q;
  logic          launch, accept, merge, fin, need_rd, is_rmw;
  logic          done_q, err_q;
  logic          hs_done, hs_err;
  logic [3:0]    strobe;
  logic [DW-1:0] eng_rdata;

  crbus_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  crbus_hs_engine #(
    .DW(DW), .SETUP_CYC(SETUP_CYC), .POLL_INT(POLL_INT), .MAX_POLLS(MAX_POLLS)
  ) u_eng (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .go      (go_q),
    .go_kind (gkind_q),
    .go_data (gdata_q),
    .ack     (bus_ack),
    .dout    (bus_dout),
    .din     (bus_din),
    .strobe  (strobe),
    .hs_done (hs_done),
    .hs_err  (hs_err),
    .rdata   (eng_rdata)
  );

  assign is_rmw  = op_q[1];
  assign need_rd = (op_q == OP_READ) || (is_rmw && !wpass_q);
  assign merged  = (eng_rdata & ~mask_q) | (wdata_q & mask_q);

  always_comb begin
    sq_d   = sq_q;
    launch = 1'b0;
    lkind  = K_CAPA;
    ldata  = addr_q;
    accept = 1'b0;
    merge  = 1'b0;
    fin    = 1'b0;
    case (sq_q)
      S_IDLE: if (cmd_start) begin
        accept = 1'b1;
        sq_d   = S_ADDR;
        launch = 1'b1;
        ldata  = cmd_addr;
      end
      S_ADDR: if (hs_err) fin = 1'b1;
        else if (hs_done) begin
          launch = 1'b1;
          if (need_rd) begin
            sq_d  = S_RD;
            lkind = K_RD;
            ldata = '0;
          end else begin
            sq_d  = S_DATA;
            lkind = K_CAPD;
            ldata = wdata_q;
          end
        end
      S_RD: if (hs_err) fin = 1'b1;
        else if (hs_done) begin
          if (is_rmw) begin
            merge  = 1'b1;
            launch = 1'b1;
            sq_d   = S_ADDR;
          end else begin
            fin = 1'b1;
          end
        end
      S_DATA: if (hs_err) fin = 1'b1;
        else if (hs_done) begin
          sq_d   = S_COMMIT;
          launch = 1'b1;
          lkind  = K_WR;
          ldata  = wdata_q;
        end
      S_COMMIT: if (hs_err || hs_done) fin = 1'b1;
      default: sq_d = S_IDLE;
    endcase
    if (fin) sq_d = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) sq_q <= S_IDLE;
    else          sq_q <= sq_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      op_q   <= OP_READ;
      addr_q <= '0;
      mask_q <= '0;
    end else if (accept) begin
      op_q   <= cmd_op;
      addr_q <= cmd_addr;
      mask_q <= cmd_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      wdata_q <= '0;
      wpass_q <= 1'b0;
    end else if (accept) begin
      wdata_q <= cmd_wdata;
      wpass_q <= 1'b0;
    end else if (merge) begin
      wdata_q <= merged;
      wpass_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      gkind_q <= K_CAPA;
      gdata_q <= '0;
    end else if (launch) begin
      gkind_q <= lkind;
      gdata_q <= ldata;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      go_q   <= launch;
      done_q <= fin;
      err_q  <= fin && hs_err;
    end
  end

  assign busy         = (sq_q != S_IDLE);
  assign done         = done_q;
  assign err          = err_q;
  assign rdata        = eng_rdata;
  assign bus_cap_addr = strobe[K_CAPA];
  assign bus_cap_data = strobe[K_CAPD];
  assign bus_rd       = strobe[K_RD];
  assign bus_wr       = strobe[K_WR];
endmodule

// File: rtl/crbus_seq_chk.sv
module crbus_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [DW-1:0] bus_din,
  input logic          bus_cap_addr,
  input logic          bus_cap_data,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          bus_ack
);
  logic any_str;
  assign any_str = bus_cap_addr | bus_cap_data | bus_rd | bus_wr;

  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_cap_addr, bus_cap_data, bus_rd, bus_wr}));

  p_din_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (any_str && $past(any_str)) |-> $stable(bus_din));

  p_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_str) |-> ($past(!any_str) && $past(!any_str, 2) && $stable(bus_din)));

  p_drop_after_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_str) |-> ($past(bus_ack) || err));

  p_rd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> (bus_din == '0));

  p_err_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_idle_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind crbus_seq crbus_seq_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .err          (err),
  .bus_din      (bus_din),
  .bus_cap_addr (bus_cap_addr),
  .bus_cap_data (bus_cap_data),
  .bus_rd       (bus_rd),
  .bus_wr       (bus_wr),
  .bus_ack      (bus_ack)
);

// File: tb/test_crbus_seq.sv
module test_crbus_seq;
  localparam int DW = 16;
  localparam int SU = 2;
  localparam int PI = 2;
  localparam int MP = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_start;
  logic [1:0] cmd_op;
  logic [DW-1:0] cmd_addr, cmd_wdata, cmd_mask;
  logic busy, done, err;
  logic [DW-1:0] rdata, bus_din, bus_dout;
  logic bus_cap_addr, bus_cap_data, bus_rd, bus_wr, bus_ack;

  always #4 clk = ~clk;

  crbus_seq #(.DW(DW), .SETUP_CYC(SU), .POLL_INT(PI), .MAX_POLLS(MP)) i_crbus_seq (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_mask(cmd_mask),
    .busy(busy), .done(done), .err(err), .rdata(rdata),
    .bus_din(bus_din), .bus_cap_addr(bus_cap_addr), .bus_cap_data(bus_cap_data),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ack(bus_ack), .bus_dout(bus_dout)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bus responder model
  int dly;
  bit dead, stuck;
  logic [DW-1:0] mem [16];
  logic [DW-1:0] expm [16];
  logic [DW-1:0] r_addr, r_data;
  int cnt, nwr, rd_bad, cm_bad;
  logic any_s;
  assign any_s = bus_cap_addr | bus_cap_data | bus_rd | bus_wr;

  always @(posedge clk) begin
    if (!rst_n) begin
      bus_ack  <= 1'b0;
      bus_dout <= '0;
      cnt      <= 0;
      r_addr   <= '0;
      r_data   <= '0;
      for (int i = 0; i < 16; i++) mem[i] <= 16'h3C00 + 16'(i * 16'h0111);
    end else if (any_s != bus_ack) begin
      if (cnt >= dly && (any_s ? !dead : !stuck)) begin
        bus_ack <= any_s;
        cnt     <= 0;
        if (bus_cap_addr) r_addr <= bus_din;
        if (bus_cap_data) r_data <= bus_din;
        if (bus_wr) begin
          mem[r_addr[3:0]] <= bus_din;
          nwr <= nwr + 1;
          if (bus_din != r_data) cm_bad <= cm_bad + 1;
        end
        if (bus_rd) begin
          bus_dout <= mem[r_addr[3:0]];
          if (bus_din != '0) rd_bad <= rd_bad + 1;
        end
      end else begin
        cnt <= cnt + 1;
      end
    end else begin
      cnt <= 0;
    end
  end

  // bus protocol monitor, falling edge
  logic p1_any, p2_any;
  logic [DW-1:0] p1_din;
  int setup_viol = 0, hold_viol = 0, multi = 0, ndone = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if ($countones({bus_cap_addr, bus_cap_data, bus_rd, bus_wr}) > 1) multi++;
      if (any_s && p1_any && bus_din != p1_din) hold_viol++;
      if (any_s && !p1_any && (p2_any || bus_din != p1_din)) setup_viol++;
      if (done) ndone++;
    end
    p2_any = p1_any;
    p1_any = any_s;
    p1_din = bus_din;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic g_err, g_done_next;
  logic [DW-1:0] g_rd;
  int g_lat;

  task automatic do_op(input logic [1:0] op, input logic [DW-1:0] a, w, m);
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_wdata = w; cmd_mask = m; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    g_lat = 1;
    while (!done && g_lat < 400) begin
      @(negedge clk);
      g_lat++;
    end
    if (g_lat >= 400) chk(1'b0, "watchdog per op", 32'(g_lat), 32'd400);
    g_err = err;
    g_rd  = rdata;
    @(negedge clk);
    g_done_next = done;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] a16, w16, old, nw;
    int d0, w0;
    rst_n = 1'b0; cmd_start = 1'b0; cmd_op = 2'b00;
    cmd_addr = '0; cmd_wdata = '0; cmd_mask = '0;
    dly = 0; dead = 0; stuck = 0; nwr = 0; rd_bad = 0; cm_bad = 0;
    for (int i = 0; i < 16; i++) expm[i] = 16'h3C00 + 16'(i * 16'h0111);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk({busy, done, err} == 3'b000, "R10 busy/done/err", {29'd0, busy, done, err}, 32'd0);
    chk(any_s == 1'b0, "R10 strobes", {31'd0, any_s}, 32'd0);
    chk(bus_din == '0 && rdata == '0, "R10 din/rdata", {bus_din, rdata}, 32'd0);

    // R4/R1 write sweep over all model registers and ack delays
    for (int a = 0; a < 16; a++) begin
      dly = a % 4;
      a16 = 16'((a << 12) | 16'h0A50 | a);
      w16 = 16'(a * 16'h1357) ^ 16'hBEEF;
      do_op(2'b01, a16, w16, 16'h0000);
      chk(!g_err, "R4 write no error", {31'd0, g_err}, 32'd0);
      chk(mem[a] == w16, "R4 write landed", {16'd0, mem[a]}, {16'd0, w16});
      chk(r_addr == a16, "R1 address captured", {16'd0, r_addr}, {16'd0, a16});
      expm[a] = w16;
    end

    // R3 read sweep
    for (int a = 0; a < 16; a++) begin
      dly = (a + 1) % 4;
      a16 = 16'((a << 12) | 16'h0C30 | a);
      do_op(2'b00, a16, 16'hFFFF, 16'hFFFF);
      chk(!g_err, "R3 read no error", {31'd0, g_err}, 32'd0);
      chk(g_rd == expm[a], "R3 read data", {16'd0, g_rd}, {16'd0, expm[a]});
      chk(r_addr == a16, "R1 read address", {16'd0, r_addr}, {16'd0, a16});
    end

    // R8 read-modify-write with several masks
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 4; j++) begin
        int a;
        a = (k * 4 + j * 5 + 1) % 16;
        dly = j;
        w16 = 16'h5A5A ^ 16'(a * 16'h0303);
        case (k)
          0: nw = 16'h0000;
          1: nw = 16'hFFFF;
          2: nw = 16'h00FF;
          default: nw = 16'hF0F0;
        endcase
        old = expm[a];
        d0 = ndone;
        do_op((j == 3) ? 2'b11 : 2'b10, 16'(a), w16, nw);
        expm[a] = (old & ~nw) | (w16 & nw);
        chk(!g_err, "R8 rmw no error", {31'd0, g_err}, 32'd0);
        chk(mem[a] == expm[a], "R8 rmw merged value", {16'd0, mem[a]}, {16'd0, expm[a]});
        chk(g_rd == old, "R8 rmw rdata is old value", {16'd0, g_rd}, {16'd0, old});
        chk(ndone - d0 == 1, "R8 single done", 32'(ndone - d0), 32'd1);
      end
    end

    // R7 start while busy is ignored
    dly = 1;
    d0 = ndone; w0 = nwr;
    @(negedge clk);
    cmd_op = 2'b01; cmd_addr = 16'h0002; cmd_wdata = 16'h1111; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R7 busy during op", {31'd0, busy}, 32'd1);
    cmd_op = 2'b01; cmd_addr = 16'h0005; cmd_wdata = 16'h2222; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    repeat (60) @(negedge clk);
    expm[2] = 16'h1111;
    chk(mem[2] == 16'h1111, "R7 first write done", {16'd0, mem[2]}, 32'h1111);
    chk(mem[5] == expm[5], "R7 ignored start left reg 5", {16'd0, mem[5]}, {16'd0, expm[5]});
    chk(ndone - d0 == 1, "R7 one done", 32'(ndone - d0), 32'd1);
    chk(nwr - w0 == 1, "R7 one commit", 32'(nwr - w0), 32'd1);
    chk(busy == 1'b0, "R7 idle after done", {31'd0, busy}, 32'd0);

    // R6 timeout: acknowledge never rises
    dead = 1; dly = 0;
    w0 = nwr;
    do_op(2'b01, 16'h0007, 16'hDEAD, 16'h0000);
    chk(g_err == 1'b1, "R6 error on no ack", {31'd0, g_err}, 32'd1);
    chk(g_lat >= PI * MP && g_lat <= PI * MP + 12, "R6 timeout latency", 32'(g_lat), 32'(PI * MP));
    chk(g_done_next == 1'b0, "R6 done one cycle", {31'd0, g_done_next}, 32'd0);
    chk(any_s == 1'b0 && busy == 1'b0, "R6 strobes low idle", {30'd0, any_s, busy}, 32'd0);
    chk(nwr == w0 && mem[7] == expm[7], "R6 no write on abort", {16'd0, mem[7]}, {16'd0, expm[7]});
    dead = 0;
    repeat (10) @(negedge clk);

    // R6 timeout: acknowledge never falls
    stuck = 1;
    do_op(2'b00, 16'h0003, 16'h0000, 16'h0000);
    chk(g_err == 1'b1, "R6 error on stuck ack", {31'd0, g_err}, 32'd1);
    stuck = 0;
    repeat (10) @(negedge clk);

    // recovery after error
    dly = 2;
    do_op(2'b00, 16'h000E, 16'h0000, 16'h0000);
    chk(!g_err && g_rd == expm[14], "R3 read after abort", {16'd0, g_rd}, {16'd0, expm[14]});

    // whole-run protocol monitors
    chk(setup_viol == 0, "R5 setup before strobe", 32'(setup_viol), 32'd0);
    chk(hold_viol == 0, "R2 din held under strobe", 32'(hold_viol), 32'd0);
    chk(multi == 0, "R9 single strobe", 32'(multi), 32'd0);
    chk(rd_bad == 0, "R3 din zero on read", 32'(rd_bad), 32'd0);
    chk(cm_bad == 0, "R4 commit value equals data", 32'(cm_bad), 32'd0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule